// File: doc/BRIEF.md
# Log Replay Checker Comparator

This block sits on the memory side of a small checker engine that re-runs one segment of a main core's execution from a recorded log. The log holds every committed load and store of that segment in program order. The block consumes the log head one entry per accepted access and never touches a cache or memory. When the engine issues a load, the block compares the engine's address with the recorded one and hands back the recorded data. When the engine issues a store, it compares both address and data with the recorded store, and no write ever leaves the block.

When the engine signals the end of the segment, the block compares the engine's final architectural registers with the closing checkpoint held in the log. The opening checkpoint needs no check here, because the checker of the previous segment confirms it as its own closing checkpoint. Any disagreement, a wrong entry type, running out of log, or log left over at the segment end sets a sticky error. The error reports a kind code and the segment-relative index of the offending entry, and holds until software clears it.

Top module: `log_replay_cmp`

## Requirements
- R1: An accepted load (`req_vld`=1, `req_st`=0, log entry type load, `log_st`=0) whose `req_addr` differs from `log_addr` raises error kind 1 (load address), with `err_idx` equal to the number of entries consumed in the current segment before that entry.
- R2: Every accepted access pulses `log_pop` in its cycle and `rsp_vld` in the next cycle. For a load, `rsp_rdata` then carries the logged `log_data`. For a store, it carries zero.
- R3: An accepted store (`req_st`=1 meeting `log_st`=1) with a wrong address raises kind 2 (store address); this takes priority when the data is also wrong. A store with the right address and wrong `req_wdata` raises kind 3 (store data).
- R4: With `seg_end`=1 and no log entries left, any difference between `eng_regs` and `ckpt_regs` (packed NREG words, register k in bits k*DW upward) raises kind 4 (checkpoint), with `err_idx` equal to the entries consumed in the segment.
- R5: A request whose type differs from the head entry type raises kind 5 (type). Address and data are then not judged.
- R6: A request while `log_avail`=0 raises kind 6 (underrun) and does not pop.
- R7: `seg_end` while `log_avail`=1 raises kind 7 (overrun). This takes priority over the checkpoint comparison. A request in the same cycle as `seg_end` is ignored: it does not pop and it is not judged.
- R8: After reset, `err_flag`=0 and `err_kind`=0. The first error is captured and holds its kind and index while later errors occur. `err_clr` alone returns the flag, kind and index to zero in the next cycle. `err_clr` together with a new error captures the new error.
- R9: `seg_end` restarts the segment entry index at zero for the following segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Engine presents an access this cycle |
| req_st | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Engine-computed address |
| req_wdata | input | DW | Engine store data |
| rsp_vld | output | 1 | Response for the access accepted last cycle |
| rsp_rdata | output | DW | Logged load data (zero after a store) |
| log_avail | input | 1 | Log head entry is valid |
| log_st | input | 1 | Head entry type: 1 = store, 0 = load |
| log_addr | input | AW | Head entry address |
| log_data | input | DW | Head entry data |
| log_pop | output | 1 | Head entry consumed this cycle |
| seg_end | input | 1 | Engine finished the segment this cycle |
| eng_regs | input | NREG*DW | Engine final registers, packed |
| ckpt_regs | input | NREG*DW | Logged end checkpoint, packed |
| err_clr | input | 1 | Clears the captured error |
| err_flag | output | 1 | Error captured |
| err_kind | output | 3 | Error kind code, 0 = none |
| err_idx | output | IW | Segment entry index of the error |

## Verification
The case where two functions meet in one cycle is an error clear arriving together with a freshly detected mismatch. The clear must not win, and the new kind and index must replace the held ones. The bench provokes this on purpose by issuing a wrong-type request with `err_clr` raised while an earlier store-address error is held. Random segments also raise `err_clr` alongside corrupted accesses. A bench model predicts the flag, kind and index after every cycle. The bench also forces overlaps of `seg_end` with leftover log entries and with corrupted registers, and the model judges which kind must win.

// File: rtl/rplc_pkg.sv
package rplc_pkg;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_LD_ADDR  = 3'd1,
    ERR_ST_ADDR  = 3'd2,
    ERR_ST_DATA  = 3'd3,
    ERR_CKPT     = 3'd4,
    ERR_TYPE     = 3'd5,
    ERR_UNDERRUN = 3'd6,
    ERR_OVERRUN  = 3'd7
  } err_kind_e;

endpackage

// File: rtl/rplc_access_cmp.sv
module rplc_access_cmp
  import rplc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          acc_vld,
  input  logic          acc_st,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  input  logic          ent_avail,
  input  logic          ent_st,
  input  logic [AW-1:0] ent_addr,
  input  logic [DW-1:0] ent_data,
  output logic          acc_err,
  output err_kind_e     acc_kind
);

  logic addr_eq;
  logic data_eq;

  assign addr_eq = (acc_addr == ent_addr);
  assign data_eq = (acc_wdata == ent_data);

  always_comb begin
    acc_err  = 1'b0;
    acc_kind = ERR_NONE;
    if (acc_vld) begin
      if (!ent_avail) begin
        acc_err  = 1'b1;
        acc_kind = ERR_UNDERRUN;
      end else if (acc_st != ent_st) begin
        acc_err  = 1'b1;
        acc_kind = ERR_TYPE;
      end else if (!addr_eq) begin
        acc_err  = 1'b1;
        acc_kind = acc_st ? ERR_ST_ADDR : ERR_LD_ADDR;
      end else if (acc_st && !data_eq) begin
        acc_err  = 1'b1;
        acc_kind = ERR_ST_DATA;
      end
    end
  end

endmodule

// File: rtl/rplc_ckpt_cmp.sv
module rplc_ckpt_cmp #(
  parameter int NREG = 8,
  parameter int DW   = 32
) (
  input  logic [NREG*DW-1:0] eng_regs,
  input  logic [NREG*DW-1:0] ckpt_regs,
  output logic               any_miss
);

  logic [NREG-1:0] reg_miss;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign reg_miss[g] = (eng_regs[g*DW +: DW] != ckpt_regs[g*DW +: DW]);
  end

  assign any_miss = |reg_miss;

endmodule

// File: rtl/rplc_err_latch.sv
module rplc_err_latch
  import rplc_pkg::*;
#(
  parameter int IW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          det_vld,
  input  err_kind_e     det_kind,
  input  logic [IW-1:0] det_idx,
  input  logic          clr,
  output logic          flag,
  output err_kind_e     kind,
  output logic [IW-1:0] idx
);

  logic          flag_q, flag_d;
  err_kind_e     kind_q, kind_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          capture;
  logic          upd_en;

  assign capture = det_vld && (!flag_q || clr);
  assign upd_en  = capture || clr;

  always_comb begin
    flag_d = flag_q;
    kind_d = kind_q;
    idx_d  = idx_q;
    if (capture) begin
      flag_d = 1'b1;
      kind_d = det_kind;
      idx_d  = det_idx;
    end else if (clr) begin
      flag_d = 1'b0;
      kind_d = ERR_NONE;
      idx_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      kind_q <= ERR_NONE;
      idx_q  <= '0;
    end else if (upd_en) begin
      flag_q <= flag_d;
      kind_q <= kind_d;
      idx_q  <= idx_d;
    end
  end

  assign flag = flag_q;
  assign kind = kind_q;
  assign idx  = idx_q;

endmodule

// File: rtl/log_replay_cmp.sv
module log_replay_cmp
  import rplc_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int NREG    = 8,
  parameter int MAX_ENT = 1024,
  localparam int IW     = $clog2(MAX_ENT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_vld,
  input  logic               req_st,
  input  logic [AW-1:0]      req_addr,
  input  logic [DW-1:0]      req_wdata,
  output logic               rsp_vld,
  output logic [DW-1:0]      rsp_rdata,
  input  logic               log_avail,
  input  logic               log_st,
  input  logic [AW-1:0]      log_addr,
  input  logic [DW-1:0]      log_data,
  output logic               log_pop,
  input  logic               seg_end,
  input  logic [NREG*DW-1:0] eng_regs,
  input  logic [NREG*DW-1:0] ckpt_regs,
  input  logic               err_clr,
  output logic               err_flag,
  output logic [2:0]         err_kind,
  output logic [IW-1:0]      err_idx
);

  logic          acc_vld;
  logic          acc_err;
  err_kind_e     acc_kind;
  logic          ckpt_miss;
  logic          det_vld;
  err_kind_e     det_kind;
  err_kind_e     kind_q;

  logic [IW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          rsp_vld_q;
  logic [DW-1:0] rdata_q, rdata_d;

  // a request coinciding with segment end is not taken
  assign acc_vld = req_vld && !seg_end;
  assign log_pop = acc_vld && log_avail;

  rplc_access_cmp #(.AW(AW), .DW(DW)) u_acc (
    .acc_vld   (acc_vld),
    .acc_st    (req_st),
    .acc_addr  (req_addr),
    .acc_wdata (req_wdata),
    .ent_avail (log_avail),
    .ent_st    (log_st),
    .ent_addr  (log_addr),
    .ent_data  (log_data),
    .acc_err   (acc_err),
    .acc_kind  (acc_kind)
  );

  rplc_ckpt_cmp #(.NREG(NREG), .DW(DW)) u_ckpt (
    .eng_regs  (eng_regs),
    .ckpt_regs (ckpt_regs),
    .any_miss  (ckpt_miss)
  );

  always_comb begin
    det_vld  = acc_err;
    det_kind = acc_kind;
    if (seg_end) begin
      det_vld  = log_avail || ckpt_miss;
      det_kind = log_avail ? ERR_OVERRUN : ERR_CKPT;
    end
  end

  rplc_err_latch #(.IW(IW)) u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .det_vld  (det_vld),
    .det_kind (det_kind),
    .det_idx  (cnt_q),
    .clr      (err_clr),
    .flag     (err_flag),
    .kind     (kind_q),
    .idx      (err_idx)
  );

  assign err_kind = kind_q;

  // segment entry counter
  assign cnt_en = seg_end || log_pop;

  always_comb begin
    if (seg_end) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // response path
  assign rdata_d = req_st ? '0 : log_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_vld_q <= 1'b0;
    else        rsp_vld_q <= log_pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (log_pop) rdata_q <= rdata_d;
  end

  assign rsp_vld   = rsp_vld_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/rplc_sva.sv
module rplc_sva #(
  parameter int DW   = 32,
  parameter int NREG = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_vld,
  input logic               req_st,
  input logic               log_avail,
  input logic               log_st,
  input logic [DW-1:0]      log_data,
  input logic               log_pop,
  input logic               seg_end,
  input logic [NREG*DW-1:0] eng_regs,
  input logic [NREG*DW-1:0] ckpt_regs,
  input logic               err_clr,
  input logic               err_flag,
  input logic [2:0]         err_kind,
  input logic               rsp_vld,
  input logic [DW-1:0]      rsp_rdata
);

  AST_POP_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    log_pop |-> log_avail);  // R6

  AST_RSP_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
    log_pop |=> rsp_vld);  // R2

  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !log_pop |=> !rsp_vld);  // R2

  AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (log_pop && !log_st && !req_st) |=> (rsp_rdata == $past(log_data)));  // R2

  AST_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !seg_end && !log_avail && !err_flag) |=> (err_flag && err_kind == 3'd6));  // R6

  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_end && log_avail && !err_flag) |=> (err_flag && err_kind == 3'd7));  // R7

  AST_CKPT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_end && !log_avail && (eng_regs != ckpt_regs) && !err_flag) |=> (err_kind == 3'd4));  // R4

  AST_SEG_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    seg_end |-> !log_pop);  // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> (err_flag && $stable(err_kind)));  // R8

endmodule

bind log_replay_cmp rplc_sva #(.DW(DW), .NREG(NREG)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vld   (req_vld),
  .req_st    (req_st),
  .log_avail (log_avail),
  .log_st    (log_st),
  .log_data  (log_data),
  .log_pop   (log_pop),
  .seg_end   (seg_end),
  .eng_regs  (eng_regs),
  .ckpt_regs (ckpt_regs),
  .err_clr   (err_clr),
  .err_flag  (err_flag),
  .err_kind  (err_kind),
  .rsp_vld   (rsp_vld),
  .rsp_rdata (rsp_rdata)
);

// File: tb/log_replay_cmp_tb.sv
module log_replay_cmp_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 32;
  localparam int DW   = 32;
  localparam int NREG = 8;
  localparam int IW   = 11;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               req_vld, req_st;
  logic [AW-1:0]      req_addr;
  logic [DW-1:0]      req_wdata;
  logic               rsp_vld;
  logic [DW-1:0]      rsp_rdata;
  logic               log_avail, log_st;
  logic [AW-1:0]      log_addr;
  logic [DW-1:0]      log_data;
  logic               log_pop;
  logic               seg_end;
  logic [NREG*DW-1:0] eng_regs, ckpt_regs;
  logic               err_clr;
  logic               err_flag;
  logic [2:0]         err_kind;
  logic [IW-1:0]      err_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  log_replay_cmp u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_vld(req_vld), .req_st(req_st), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata),
    .log_avail(log_avail), .log_st(log_st), .log_addr(log_addr), .log_data(log_data),
    .log_pop(log_pop), .seg_end(seg_end), .eng_regs(eng_regs), .ckpt_regs(ckpt_regs),
    .err_clr(err_clr), .err_flag(err_flag), .err_kind(err_kind), .err_idx(err_idx)
  );

  // bench log storage
  logic          lg_st   [256];
  logic [31:0]   lg_addr [256];
  logic [31:0]   lg_data [256];
  int            lg_n = 0;
  int            rd_ptr = 0;

  // bench model state
  int            m_flag = 0, m_kind = 0, m_idx = 0, m_cnt = 0;
  logic [31:0]   m_rdata = '0;

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic push(input logic st, input logic [31:0] a, input logic [31:0] d);
    lg_st[lg_n & 255]   = st;
    lg_addr[lg_n & 255] = a;
    lg_data[lg_n & 255] = d;
    lg_n++;
  endtask

  function automatic int expect_kind(input logic rq, input logic st, input logic [31:0] a,
                                     input logic [31:0] d, input logic sg, input logic avail);
    int h;
    h = rd_ptr & 255;
    if (sg) begin
      if (avail) return 7;
      if (eng_regs != ckpt_regs) return 4;
      return 0;
    end
    if (!rq) return 0;
    if (!avail) return 6;
    if (st != lg_st[h]) return 5;
    if (a != lg_addr[h]) return st ? 2 : 1;
    if (st && d != lg_data[h]) return 3;
    return 0;
  endfunction

  task automatic step(input logic rq, input logic st, input logic [31:0] a,
                      input logic [31:0] d, input logic sg, input logic cl, input string tag);
    logic avail, pop;
    int   k;
    @(negedge clk);
    avail     = (rd_ptr < lg_n);
    log_avail = avail;
    log_st    = lg_st[rd_ptr & 255];
    log_addr  = lg_addr[rd_ptr & 255];
    log_data  = lg_data[rd_ptr & 255];
    req_vld = rq; req_st = st; req_addr = a; req_wdata = d;
    seg_end = sg; err_clr = cl;
    k   = expect_kind(rq, st, a, d, sg, avail);
    pop = rq && avail && !sg;
    #1;
    check({tag, " R6/R7 log_pop"}, log_pop, pop);
    @(posedge clk);
    #1;
    if (k != 0 && (m_flag == 0 || cl)) begin
      m_flag = 1; m_kind = k; m_idx = m_cnt;
    end else if (cl) begin
      m_flag = 0; m_kind = 0; m_idx = 0;
    end
    if (pop) begin
      m_rdata = st ? 32'h0 : lg_data[rd_ptr & 255];
      rd_ptr++;
    end
    if (sg) m_cnt = 0;
    else if (pop) m_cnt++;
    check({tag, " R8 err_flag"}, err_flag, m_flag);
    check({tag, " err_kind"}, err_kind, m_kind);
    check({tag, " R9 err_idx"}, err_idx, m_idx);
    check({tag, " R2 rsp_vld"}, rsp_vld, pop);
    if (pop) check({tag, " R2 rsp_rdata"}, rsp_rdata, m_rdata);
    req_vld = 0; seg_end = 0; err_clr = 0;
  endtask

  task automatic exact(input string tag);
    int h;
    h = rd_ptr & 255;
    step(1, lg_st[h], lg_addr[h], lg_data[h], 0, 0, tag);
  endtask

  task automatic idle(input logic cl, input string tag);
    step(0, 0, 0, 0, 0, cl, tag);
  endtask

  task automatic seg(input string tag);
    step(0, 0, 0, 0, 1, 0, tag);
  endtask

  task automatic new_regs();
    for (int k = 0; k < NREG; k++) ckpt_regs[k*DW +: DW] = $urandom;
    eng_regs = ckpt_regs;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int h;
    void'($urandom(32'h5eed_1234));
    rst_n = 0; req_vld = 0; req_st = 0; req_addr = 0; req_wdata = 0;
    log_avail = 0; log_st = 0; log_addr = 0; log_data = 0;
    seg_end = 0; err_clr = 0;
    new_regs();
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset err_flag", err_flag, 0);
    check("R8 reset err_kind", err_kind, 0);
    check("R2 reset rsp_vld", rsp_vld, 0);
    check("R6 reset log_pop", log_pop, 0);
    @(negedge clk); rst_n = 1;

    // clean segment: loads return logged data, stores compare
    push(0, 32'h100, 32'hAAAA0001); push(1, 32'h104, 32'hBBBB0002);
    push(0, 32'h108, 32'hCCCC0003); push(0, 32'h10C, 32'hDDDD0004);
    push(1, 32'h110, 32'hEEEE0005); push(1, 32'h114, 32'hFFFF0006);
    for (int i = 0; i < 6; i++) exact("R2 clean access");
    new_regs();
    seg("R4 clean checkpoint");

    // error segment
    push(0, 32'h200, 32'h1); push(1, 32'h204, 32'h2);
    push(1, 32'h208, 32'h3); push(0, 32'h20C, 32'h4);
    step(1, 0, 32'h201, 0, 0, 0, "R1 load addr mismatch");
    step(1, 1, 32'h204, 32'h99, 0, 0, "R8 sticky over store data");
    idle(1, "R8 clear");
    step(1, 1, 32'h209, 32'h77, 0, 0, "R3 store addr+data");
    step(1, 1, 32'h20C, 32'h4, 0, 1, "R5 type with clear");
    idle(1, "R8 clear");
    step(1, 0, 32'h300, 0, 0, 0, "R6 underrun");
    idle(1, "R8 clear");
    seg("R9 seg close");

    // overrun
    push(0, 32'h400, 32'h11); push(1, 32'h404, 32'h12); push(0, 32'h408, 32'h13);
    exact("R2 pre-overrun");
    step(1, 0, 32'h404, 0, 1, 0, "R7 overrun, request ignored");
    rd_ptr = lg_n;
    idle(1, "R8 clear");

    // checkpoint mismatch
    push(1, 32'h500, 32'h21); push(0, 32'h504, 32'h22);
    exact("R3 store ok"); exact("R2 load ok");
    new_regs();
    eng_regs[5*DW + 7] = ~eng_regs[5*DW + 7];
    seg("R4 checkpoint mismatch");
    idle(1, "R8 clear");
    new_regs();

    // index restart and store data only
    push(0, 32'h600, 32'h31); push(1, 32'h604, 32'h32);
    step(1, 0, 32'h6F0, 0, 0, 0, "R9 index restart");
    idle(1, "R8 clear");
    step(1, 1, 32'h604, 32'h33, 0, 0, "R3 store data");
    idle(1, "R8 clear");
    seg("R4 close");

    // random segments
    for (int s = 0; s < 40; s++) begin
      int n;
      bit early;
      n = 1 + ($urandom % 20);
      for (int i = 0; i < n; i++) push($urandom % 2, $urandom, $urandom);
      early = 0;
      for (int i = 0; i < n; i++) begin
        int r;
        if ($urandom % 12 == 0) begin early = 1; break; end
        h = rd_ptr & 255;
        r = $urandom % 16;
        case (r)
          0: step(1, lg_st[h], lg_addr[h] ^ 32'h10, lg_data[h], 0, 0, "R1/R3 rnd addr");
          1: step(1, lg_st[h], lg_addr[h], lg_data[h] ^ 32'h1, 0, 0, "R3 rnd data");
          2: step(1, ~lg_st[h], lg_addr[h], lg_data[h], 0, 0, "R5 rnd type");
          3: begin idle(1, "R8 rnd clear"); i--; end
          4: step(1, lg_st[h], lg_addr[h] ^ 32'h4, lg_data[h], 0, 1, "R8 rnd clear+err");
          default: exact("R2 rnd exact");
        endcase
      end
      if (!early && $urandom % 6 == 0) step(1, 0, $urandom, 0, 0, 0, "R6 rnd underrun");
      new_regs();
      if ($urandom % 5 == 0) eng_regs[($urandom % (NREG*DW))] ^= 1'b1;
      seg(early ? "R7 rnd overrun" : "R4 rnd close");
      rd_ptr = lg_n;
      if ($urandom % 2 == 0) idle(1, "R8 rnd clear");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule